// File: doc/BRIEF.md
# Multiply/Divide Issue Interlock

This block decides, cycle by cycle, whether a multiply, an integer divide, a write of the HI or LO result register, or a read of HI or LO may issue. It models timing only and computes no arithmetic. One request may be presented per cycle on a valid/ready port. The request carries an operation code and a width bit. The block answers with `req_ready` for the op being offered. It also drives a standing issue-allowed flag for every op class, so that an issue stage can choose among several candidates.

The integer divider is not pipelined. A divide first spends a short lead-in (three cycles by default). The shared divider then stays occupied for 32 or 64 cycles, and the result lands at the end of that. A following divide is admitted as soon as its own occupancy would start just after the previous one ends. The lead-in of the new divide therefore overlaps the tail of the old one. HI and LO each have their own readiness countdown. Every producer reloads the countdown with its own latency: multiply, divide or direct write.

Back-pressure rules: an op is issued in the cycle where `req_valid` and `req_ready` are both high. When `req_ready` is low, the request is simply not taken and changes no state. The requester may hold it or withdraw it. `req_ready` is a function of the present state and `req_op` only, never of `req_valid`.

Top module: `muldiv_issue_gate`

## Requirements
- R1: After reset every allow output is high and `div_stall` is low.
- R2: An op is issued only in a cycle where `req_valid` and `req_ready` are both high, and `req_ready` equals the allow flag of the op on `req_op`. A request refused by `req_ready` low leaves all allow outputs as they would have been without it.
- R3: After a divide issues in cycle t, another divide is refused until cycle t+32 (`req_wide`=0) or t+64 (`req_wide`=1), and is accepted in that cycle if no other rule blocks it.
- R4: After a divide issues in cycle t, reads of HI and LO, multiplies and HI/LO writes are refused until cycle t+36 (32-bit) or t+68 (64-bit).
- R5: After a 32-bit multiply issues in cycle t, reads of HI and LO are refused until t+3.
- R6: After a 64-bit multiply issues in cycle t, reading LO is allowed from t+3 and reading HI from t+4. A further multiply is refused in t+1 and allowed from t+2.
- R7: After a write of HI (or LO) issues in cycle t, reading that register is allowed from t+3 and the other register's readiness is untouched. Multiply and divide are refused until t+4.
- R8: Each accepted producer reloads the readiness of the registers it writes with its own latency, replacing any earlier value.
- R9: `div_stall` is high exactly when a valid divide request is offered and divides are not allowed.
- R10: Op encoding on `req_op`: 0 multiply, 1 divide, 2 write HI, 3 write LO, 4 read HI, 5 read LO. Codes 6 and 7 are never ready and have no effect. `req_wide`=1 selects the 64-bit form of multiply and divide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Issue request present |
| req_op | input | 3 | Operation code (see R10) |
| req_wide | input | 1 | 64-bit operand size for multiply/divide |
| req_ready | output | 1 | Offered op may issue this cycle |
| allow_mul | output | 1 | Multiply may issue |
| allow_div | output | 1 | Divide may issue |
| allow_mt | output | 1 | Write of HI or LO may issue |
| allow_mfhi | output | 1 | Read of HI may issue |
| allow_mflo | output | 1 | Read of LO may issue |
| div_stall | output | 1 | Valid divide request held off |

## Verification
A corrupted divider occupancy count shows up as an `allow_div` edge that arrives too early or too late. That edge can sit up to 64 cycles after the divide. Only a long enough string of repeated divide requests exposes the exact cycle, so the bench drives such strings directly. A wrong HI or LO countdown shows up as a wrong read permission within 3 to 68 cycles of its producer. A reload that fails to replace an earlier value is only visible when a second producer follows within the first one's window. Random mixes with dense requests provide those overlaps.

// File: rtl/mdg_pkg.sv
package mdg_pkg;

  typedef enum logic [2:0] {
    OP_MUL  = 3'd0,
    OP_DIV  = 3'd1,
    OP_MTHI = 3'd2,
    OP_MTLO = 3'd3,
    OP_MFHI = 3'd4,
    OP_MFLO = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } mdg_op_e;

  // timer slots
  localparam int NT     = 6;
  localparam int T_DGAP = 0;  // divider occupancy gap
  localparam int T_DRES = 1;  // divide result outstanding
  localparam int T_MTB  = 2;  // HI/LO write to mul/div
  localparam int T_MULB = 3;  // wide multiply back-off
  localparam int T_HI   = 4;  // HI readable
  localparam int T_LO   = 5;  // LO readable

endpackage

// File: rtl/mdg_countdown.sv
module mdg_countdown #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          idle
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign idle = (cnt == '0);
endmodule

// File: rtl/mdg_load_sel.sv
module mdg_load_sel
  import mdg_pkg::*;
#(
  parameter int CW        = 7,
  parameter int DIV_OCC_N = 32,
  parameter int DIV_OCC_W = 64,
  parameter int DIV_LAT_N = 36,
  parameter int DIV_LAT_W = 68,
  parameter int MUL_LAT   = 3,
  parameter int MUL_HI_EX = 1,
  parameter int MUL_BLOCK = 1,
  parameter int MT_MF_LAT = 3,
  parameter int MT_MD_LAT = 4
) (
  input  logic                  fire,
  input  mdg_op_e               op,
  input  logic                  wide,
  output logic [NT-1:0]         ld,
  output logic [NT-1:0][CW-1:0] val
);
  localparam logic [CW-1:0] V_GAP_N  = CW'(DIV_OCC_N - 1);
  localparam logic [CW-1:0] V_GAP_W  = CW'(DIV_OCC_W - 1);
  localparam logic [CW-1:0] V_RES_N  = CW'(DIV_LAT_N - 1);
  localparam logic [CW-1:0] V_RES_W  = CW'(DIV_LAT_W - 1);
  localparam logic [CW-1:0] V_MUL    = CW'(MUL_LAT - 1);
  localparam logic [CW-1:0] V_MUL_HI = CW'(MUL_LAT + MUL_HI_EX - 1);
  localparam logic [CW-1:0] V_MULB   = CW'(MUL_BLOCK);
  localparam logic [CW-1:0] V_MT_MF  = CW'(MT_MF_LAT - 1);
  localparam logic [CW-1:0] V_MT_MD  = CW'(MT_MD_LAT - 1);

  always_comb begin
    ld  = '0;
    val = '0;
    if (fire) begin
      unique case (op)
        OP_MUL: begin
          ld[T_HI]  = 1'b1;
          ld[T_LO]  = 1'b1;
          val[T_LO] = V_MUL;
          val[T_HI] = wide ? V_MUL_HI : V_MUL;
          if (wide) begin
            ld[T_MULB]  = 1'b1;
            val[T_MULB] = V_MULB;
          end
        end
        OP_DIV: begin
          ld[T_DGAP]  = 1'b1;
          ld[T_DRES]  = 1'b1;
          ld[T_HI]    = 1'b1;
          ld[T_LO]    = 1'b1;
          val[T_DGAP] = wide ? V_GAP_W : V_GAP_N;
          val[T_DRES] = wide ? V_RES_W : V_RES_N;
          val[T_HI]   = wide ? V_RES_W : V_RES_N;
          val[T_LO]   = wide ? V_RES_W : V_RES_N;
        end
        OP_MTHI: begin
          ld[T_HI]   = 1'b1;
          ld[T_MTB]  = 1'b1;
          val[T_HI]  = V_MT_MF;
          val[T_MTB] = V_MT_MD;
        end
        OP_MTLO: begin
          ld[T_LO]   = 1'b1;
          ld[T_MTB]  = 1'b1;
          val[T_LO]  = V_MT_MF;
          val[T_MTB] = V_MT_MD;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mdg_gate.sv
module mdg_gate
  import mdg_pkg::*;
(
  input  logic          req_valid,
  input  mdg_op_e       op,
  input  logic [NT-1:0] idle,
  output logic          allow_mul,
  output logic          allow_div,
  output logic          allow_mt,
  output logic          allow_mfhi,
  output logic          allow_mflo,
  output logic          ready,
  output logic          div_stall
);
  always_comb begin
    allow_mul  = idle[T_MTB] & idle[T_DRES] & idle[T_MULB];
    allow_div  = idle[T_DGAP] & idle[T_MTB];
    allow_mt   = idle[T_DRES];
    allow_mfhi = idle[T_HI];
    allow_mflo = idle[T_LO];
    unique case (op)
      OP_MUL:          ready = allow_mul;
      OP_DIV:          ready = allow_div;
      OP_MTHI, OP_MTLO: ready = allow_mt;
      OP_MFHI:         ready = allow_mfhi;
      OP_MFLO:         ready = allow_mflo;
      default:         ready = 1'b0;
    endcase
    div_stall = req_valid & (op == OP_DIV) & ~allow_div;
  end
endmodule

// File: rtl/muldiv_issue_gate.sv
module muldiv_issue_gate
  import mdg_pkg::*;
#(
  parameter int DIV_LEAD  = 3,
  parameter int DIV_OCC_N = 32,
  parameter int DIV_OCC_W = 64,
  parameter int MUL_LAT   = 3,
  parameter int MUL_HI_EX = 1,
  parameter int MUL_BLOCK = 1,
  parameter int MT_MF_LAT = 3,
  parameter int MT_MD_LAT = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [2:0] req_op,
  input  logic       req_wide,
  output logic       req_ready,
  output logic       allow_mul,
  output logic       allow_div,
  output logic       allow_mt,
  output logic       allow_mfhi,
  output logic       allow_mflo,
  output logic       div_stall
);
  localparam int DIV_LAT_N = 1 + DIV_LEAD + DIV_OCC_N;
  localparam int DIV_LAT_W = 1 + DIV_LEAD + DIV_OCC_W;
  localparam int CW        = $clog2(DIV_LAT_W + 1);

  mdg_op_e               op;
  logic                  fire;
  logic [NT-1:0]         ld;
  logic [NT-1:0][CW-1:0] val;
  logic [NT-1:0]         idle;

  assign op   = mdg_op_e'(req_op);
  assign fire = req_valid & req_ready;

  mdg_load_sel #(
    .CW(CW), .DIV_OCC_N(DIV_OCC_N), .DIV_OCC_W(DIV_OCC_W),
    .DIV_LAT_N(DIV_LAT_N), .DIV_LAT_W(DIV_LAT_W),
    .MUL_LAT(MUL_LAT), .MUL_HI_EX(MUL_HI_EX), .MUL_BLOCK(MUL_BLOCK),
    .MT_MF_LAT(MT_MF_LAT), .MT_MD_LAT(MT_MD_LAT)
  ) u_sel (
    .fire(fire), .op(op), .wide(req_wide), .ld(ld), .val(val)
  );

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    mdg_countdown #(.CW(CW)) u_cnt (
      .clk(clk), .rst(rst), .load(ld[i]), .load_val(val[i]), .idle(idle[i])
    );
  end

  mdg_gate u_gate (
    .req_valid(req_valid), .op(op), .idle(idle),
    .allow_mul(allow_mul), .allow_div(allow_div), .allow_mt(allow_mt),
    .allow_mfhi(allow_mfhi), .allow_mflo(allow_mflo),
    .ready(req_ready), .div_stall(div_stall)
  );
endmodule

// File: rtl/muldiv_issue_gate_chk.sv
module muldiv_issue_gate_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic [2:0] req_op,
  input logic       req_wide,
  input logic       req_ready,
  input logic       allow_mul,
  input logic       allow_div,
  input logic       allow_mt,
  input logic       allow_mfhi,
  input logic       allow_mflo,
  input logic       div_stall
);
  logic acc;
  assign acc = req_valid & req_ready;

  p_div_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (acc && req_op == 3'd1) |=> !allow_div);

  p_div_result_r4: assert property (@(posedge clk) disable iff (rst)
    (acc && req_op == 3'd1) |=> (!allow_mfhi && !allow_mflo && !allow_mul && !allow_mt));

  p_mul_narrow_r5: assert property (@(posedge clk) disable iff (rst)
    (acc && req_op == 3'd0 && !req_wide) |=> (!allow_mfhi && !allow_mflo));

  p_mul_wide_r6: assert property (@(posedge clk) disable iff (rst)
    (acc && req_op == 3'd0 && req_wide) |=> (!allow_mul && !allow_mfhi));

  p_mt_block_r7: assert property (@(posedge clk) disable iff (rst)
    (acc && req_op == 3'd2) |=> (!allow_mfhi && !allow_mul && !allow_div));

  p_stall_r9: assert property (@(posedge clk) disable iff (rst)
    div_stall |-> (req_valid && !req_ready));

  p_reserved_r10: assert property (@(posedge clk) disable iff (rst)
    (req_op[2:1] == 2'b11) |-> !req_ready);

  p_refused_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && allow_mflo && req_op != 3'd0 && req_op != 3'd1
     && req_op != 3'd3) |=> allow_mflo);
endmodule

bind muldiv_issue_gate muldiv_issue_gate_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
  .req_wide(req_wide), .req_ready(req_ready), .allow_mul(allow_mul),
  .allow_div(allow_div), .allow_mt(allow_mt), .allow_mfhi(allow_mfhi),
  .allow_mflo(allow_mflo), .div_stall(div_stall)
);

// File: tb/muldiv_issue_gate_test.sv
`timescale 1ns/1ps
module muldiv_issue_gate_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic       req_wide = 1'b0;
  logic       req_ready, allow_mul, allow_div, allow_mt, allow_mfhi, allow_mflo, div_stall;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  // model: earliest window in which each permission returns
  int hi_t = 0, lo_t = 0, dgap_t = 0, dres_t = 0, mtb_t = 0, mulb_t = 0;

  always #5 clk = ~clk;

  muldiv_issue_gate uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_wide(req_wide), .req_ready(req_ready), .allow_mul(allow_mul),
    .allow_div(allow_div), .allow_mt(allow_mt), .allow_mfhi(allow_mfhi),
    .allow_mflo(allow_mflo), .div_stall(div_stall)
  );

  function automatic bit e_mul();  return cyc >= mtb_t && cyc >= dres_t && cyc >= mulb_t; endfunction
  function automatic bit e_div();  return cyc >= dgap_t && cyc >= mtb_t; endfunction
  function automatic bit e_mt();   return cyc >= dres_t; endfunction
  function automatic bit e_mfhi(); return cyc >= hi_t; endfunction
  function automatic bit e_mflo(); return cyc >= lo_t; endfunction

  function automatic bit e_ready(input logic [2:0] op);
    case (op)
      3'd0: return e_mul();
      3'd1: return e_div();
      3'd2, 3'd3: return e_mt();
      3'd4: return e_mfhi();
      3'd5: return e_mflo();
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0b expected %0b", tag, cyc, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [2:0] op, input bit w);
    bit er;
    req_valid = v; req_op = op; req_wide = w;
    @(negedge clk);
    er = e_ready(op);
    chk("allow_mul R4 R6 R7", allow_mul, e_mul());
    chk("allow_div R3 R7", allow_div, e_div());
    chk("allow_mt R4", allow_mt, e_mt());
    chk("allow_mfhi R4 R5 R6 R7 R8", allow_mfhi, e_mfhi());
    chk("allow_mflo R4 R5 R6 R7 R8", allow_mflo, e_mflo());
    chk("req_ready R2 R10", req_ready, er);
    chk("div_stall R9", div_stall, v && op == 3'd1 && !e_div());
    if (v && er) begin
      case (op)
        3'd0: begin
          lo_t = cyc + 3;
          hi_t = cyc + (w ? 4 : 3);
          if (w) mulb_t = cyc + 2;
        end
        3'd1: begin
          dgap_t = cyc + (w ? 64 : 32);
          dres_t = cyc + (w ? 68 : 36);
          hi_t = dres_t; lo_t = dres_t;
        end
        3'd2: begin hi_t = cyc + 3; mtb_t = cyc + 4; end
        3'd3: begin lo_t = cyc + 3; mtb_t = cyc + 4; end
        default: ;
      endcase
    end
    @(posedge clk);
    cyc++;
    #1;
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 3'd0, 1'b0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: reset state
    @(negedge clk);
    chk("reset R1 allow_mul", allow_mul, 1'b1);
    chk("reset R1 allow_div", allow_div, 1'b1);
    chk("reset R1 allow_mt", allow_mt, 1'b1);
    chk("reset R1 allow_mfhi", allow_mfhi, 1'b1);
    chk("reset R1 allow_mflo", allow_mflo, 1'b1);
    chk("reset R1 div_stall", div_stall, 1'b0);
    @(posedge clk); #1;

    // R3 R9: back-to-back 32-bit divides held until the gap closes
    for (int i = 0; i < 40; i++) step(1'b1, 3'd1, 1'b0);
    idle_n(70);
    // R3 R4: 64-bit divide, then LO reads offered until granted
    step(1'b1, 3'd1, 1'b1);
    for (int i = 0; i < 70; i++) step(1'b1, 3'd5, 1'b0);
    idle_n(10);
    // R6: wide multiply then multiply and HI read
    step(1'b1, 3'd0, 1'b1);
    step(1'b1, 3'd0, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b1, 3'd4, 1'b0);
    // R7 R8: write HI after multiply, then reads and multiply
    step(1'b1, 3'd0, 1'b0);
    step(1'b1, 3'd2, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b1, 3'd0, 1'b0);
    step(1'b1, 3'd3, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b1, 3'd5, 1'b0);
    // R10: reserved codes are refused and have no effect
    step(1'b1, 3'd7, 1'b1);
    step(1'b1, 3'd6, 1'b0);
    idle_n(2);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [2:0] op;
      r = int'($urandom_range(0, 99));
      if (r < 4)       op = 3'd1;
      else if (r < 30) op = 3'd0;
      else if (r < 50) op = 3'(2 + (r & 1));
      else             op = 3'(4 + (r & 1));
      step($urandom_range(0, 9) < 7, op, $urandom_range(0, 1) == 1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule